// File: doc/BRIEF.md
# Tagged Translation Buffer with Selective Invalidation

This block is a small, fully associative address translation buffer. Every slot stores a virtual page number together with its own page-size shift, a physical frame number, an address-space tag, a protection domain, permission bits, an execute-never flag, a non-cacheable flag and a valid flag. A lookup presents a virtual address and the current address-space tag. One cycle later the block answers with hit or miss, the translated physical address and the slot's attributes. Slots are written through an external fill port by index. The walker that produces those fills and the permission checker that consumes the attributes sit outside this block.

Software maintenance is handled by a one-cycle invalidation command that comes in three forms. The first removes every slot that a lookup of a given address and tag would hit. The second removes every slot carrying a given tag, whatever its address. The third removes every slot whose own page range contains a given address, whatever its tag. Six saturating event counters record hits, misses and accesses, kept apart for reads and for writes. Three totals are formed as read-plus-write sums.

Top module: `tlb_tagged`

## Requirements
- R1: A lookup hits only when the slot is valid, its tag equals `lk_ctx`, and `lk_va >> shift` equals the slot's page number, so the slot covers [page<<shift, (page<<shift) + 2^shift). The response (`rsp_valid`, `rsp_hit`) is registered and appears on the clock edge after the request, and it reflects the contents held before that edge.
- R2: On a hit, `rsp_pa` = (frame << shift) | (va & (2^shift - 1)), truncated to PA_W, and the attributes come from that slot. When several slots hit, the lowest index wins. On a miss, the address and attributes read as zero.
- R3: Invalidation kind 1 (address and tag) clears every valid slot that a lookup of `inv_va`/`inv_asid` would hit, including overlapping slots of different sizes. It leaves slots with another tag untouched.
- R4: Invalidation kind 2 (tag only) clears every slot whose tag equals `inv_asid`, regardless of its address.
- R5: Invalidation kind 3 (address only) clears every slot whose own page range contains `inv_va`, regardless of tag. Slots whose range does not contain it are kept.
- R6: An invalidation completes on the edge where `inv_en` is sampled, so a lookup issued in the following cycle already sees the result. `inv_done` is high for exactly the cycle after each command. Kind 0 clears nothing but still completes.
- R7: When a fill and an invalidation occur in the same cycle, the invalidation acts first and the fill is written afterwards. The filled slot is left valid with the new contents, and other slots are invalidated normally.
- R8: Read hits, read misses, read accesses, write hits, write misses and write accesses are each counted in their own counter (`lk_write`=1 marks a write). The count is updated on the same edge that registers the response.
- R9: `cnt_hit`, `cnt_miss` and `cnt_acc` are CNT_W+1 bits wide and always equal the sum of the matching read and write counters.
- R10: Each of the six counters is CNT_W bits wide (32 by default) and stops at its maximum value instead of wrapping.
- R11: An active-low reset invalidates every slot, clears every counter and drops `rsp_valid` and `inv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_va | input | VA_W | Lookup virtual address |
| lk_ctx | input | ASID_W | Current address-space tag |
| fill_en | input | 1 | Write a slot |
| fill_idx | input | clog2(ENTRIES) | Slot index to write |
| fill_vpn | input | VA_W | Virtual page number |
| fill_shift | input | SHIFT_W | Page-size shift |
| fill_pfn | input | PA_W | Physical frame number |
| fill_asid | input | ASID_W | Address-space tag |
| fill_domain | input | DOM_W | Protection domain |
| fill_ap | input | AP_W | Permission bits |
| fill_xn | input | 1 | Execute-never flag |
| fill_nc | input | 1 | Non-cacheable flag |
| inv_en | input | 1 | Invalidation command |
| inv_kind | input | 2 | 0 none, 1 address+tag, 2 tag, 3 address |
| inv_va | input | VA_W | Invalidation address |
| inv_asid | input | ASID_W | Invalidation tag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_domain | output | DOM_W | Domain of the hit slot |
| rsp_ap | output | AP_W | Permission bits of the hit slot |
| rsp_xn | output | 1 | Execute-never of the hit slot |
| rsp_nc | output | 1 | Non-cacheable of the hit slot |
| inv_done | output | 1 | Invalidation completed |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_rd_acc | output | CNT_W | Read accesses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wr_acc | output | CNT_W | Write accesses |
| cnt_hit | output | CNT_W+1 | Total hits |
| cnt_miss | output | CNT_W+1 | Total misses |
| cnt_acc | output | CNT_W+1 | Total accesses |

## Verification
The hardest case to reach from the ports is several valid slots of different sizes and tags that overlap the same address. The case is then made harder by a fill landing on one of those slots in the same cycle as an invalidation that matches it. Random stimulus rarely builds this arrangement, so directed sequences first place a large page and smaller pages inside it, under both equal and different tags. They then fire each invalidation kind, alone and together with a fill, and probe every region with lookups afterwards. Random traffic aims half of its lookups and invalidations inside ranges that are currently filled, so hits, priority between overlapping slots and same-cycle fill and invalidation keep recurring.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    INV_NONE    = 2'd0,
    INV_VA_ASID = 2'd1,
    INV_ASID    = 2'd2,
    INV_VA      = 2'd3
  } inv_kind_e;

  localparam int NUM_CNT     = 6;
  localparam int CNT_RD_HIT  = 0;
  localparam int CNT_RD_MISS = 1;
  localparam int CNT_RD_ACC  = 2;
  localparam int CNT_WR_HIT  = 3;
  localparam int CNT_WR_MISS = 4;
  localparam int CNT_WR_ACC  = 5;

endpackage

// File: rtl/tlb_sat_counter.sv
module tlb_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);

  logic at_max;
  assign at_max = (q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)             q <= '0;
    else if (inc && !at_max) q <= q + 1'b1;
  end

  AST_CNT_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (q == {W{1'b1}}) |=> (q == {W{1'b1}}));              // R10
  AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(q));                                 // R8

endmodule

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int DOM_W   = 4,
  parameter int AP_W    = 3,
  parameter int SHIFT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [SHIFT_W-1:0] wr_shift,
  input  logic [PA_W-1:0]   wr_pfn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [DOM_W-1:0]  wr_dom,
  input  logic [AP_W-1:0]   wr_ap,
  input  logic              wr_xn,
  input  logic              wr_nc,
  input  logic              inv_en,
  input  inv_kind_e         inv_kind,
  input  logic [VA_W-1:0]   inv_va,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [DOM_W-1:0]  dom_q,
  output logic [AP_W-1:0]   ap_q,
  output logic              xn_q,
  output logic              nc_q,
  output logic              valid_q
);

  logic [VA_W-1:0]    vpn_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [PA_W-1:0]    pfn_q;
  logic [ASID_W-1:0]  asid_q;

  // Address falls inside the page that starts at vpn<<sh and spans 2^sh bytes.
  function automatic logic in_page(input logic [VA_W-1:0] va,
                                   input logic [VA_W-1:0] vpn,
                                   input logic [SHIFT_W-1:0] sh);
    return (va >> sh) == vpn;
  endfunction

  function automatic logic [PA_W-1:0] to_phys(input logic [VA_W-1:0] va,
                                              input logic [PA_W-1:0] pfn,
                                              input logic [SHIFT_W-1:0] sh);
    logic [PA_W-1:0] off_mask;
    off_mask = ~({PA_W{1'b1}} << sh);
    return (pfn << sh) | (PA_W'(va) & off_mask);
  endfunction

  logic va_in_range;   // named event: invalidation address lies in this page
  logic asid_same;     // named event: invalidation tag equals this slot's tag
  logic inv_hit;       // named event: this slot is cleared by the command

  assign lk_hit      = valid_q && (asid_q == lk_asid) && in_page(lk_va, vpn_q, shift_q);
  assign lk_pa       = to_phys(lk_va, pfn_q, shift_q);
  assign va_in_range = in_page(inv_va, vpn_q, shift_q);
  assign asid_same   = (asid_q == inv_asid);

  always_comb begin
    unique case (inv_kind)
      INV_VA_ASID: inv_hit = inv_en && valid_q && va_in_range && asid_same;
      INV_ASID:    inv_hit = inv_en && asid_same;
      INV_VA:      inv_hit = inv_en && va_in_range;
      default:     inv_hit = 1'b0;
    endcase
  end

  // Invalidation first, then the fill; the later assignment wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      shift_q <= '0;
      pfn_q   <= '0;
      asid_q  <= '0;
      dom_q   <= '0;
      ap_q    <= '0;
      xn_q    <= 1'b0;
      nc_q    <= 1'b0;
    end else begin
      if (inv_hit) valid_q <= 1'b0;
      if (wr_en) begin
        valid_q <= 1'b1;
        vpn_q   <= wr_vpn;
        shift_q <= wr_shift;
        pfn_q   <= wr_pfn;
        asid_q  <= wr_asid;
        dom_q   <= wr_dom;
        ap_q    <= wr_ap;
        xn_q    <= wr_xn;
        nc_q    <= wr_nc;
      end
    end
  end

  AST_PAIR_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_kind == INV_VA_ASID && !wr_en && asid_q == inv_asid
     && (inv_va >> shift_q) == vpn_q) |=> !valid_q);                          // R3
  AST_PAIR_INV_KEEPS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_kind == INV_VA_ASID && valid_q && asid_q != inv_asid) |=> valid_q); // R3
  AST_ASID_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_kind == INV_ASID && !wr_en && asid_q == inv_asid) |=> !valid_q); // R4
  AST_VA_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_kind == INV_VA && !wr_en && (inv_va >> shift_q) == vpn_q) |=> !valid_q); // R5
  AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q && vpn_q == $past(wr_vpn) && asid_q == $past(wr_asid))); // R7

endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int DOM_W   = 4,
  parameter int AP_W    = 3,
  parameter int SHIFT_W = 5,
  parameter int CNT_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic                       lk_write,
  input  logic [VA_W-1:0]            lk_va,
  input  logic [ASID_W-1:0]          lk_ctx,
  input  logic                       fill_en,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic [VA_W-1:0]            fill_vpn,
  input  logic [SHIFT_W-1:0]         fill_shift,
  input  logic [PA_W-1:0]            fill_pfn,
  input  logic [ASID_W-1:0]          fill_asid,
  input  logic [DOM_W-1:0]           fill_domain,
  input  logic [AP_W-1:0]            fill_ap,
  input  logic                       fill_xn,
  input  logic                       fill_nc,
  input  logic                       inv_en,
  input  logic [1:0]                 inv_kind,
  input  logic [VA_W-1:0]            inv_va,
  input  logic [ASID_W-1:0]          inv_asid,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [PA_W-1:0]            rsp_pa,
  output logic [DOM_W-1:0]           rsp_domain,
  output logic [AP_W-1:0]            rsp_ap,
  output logic                       rsp_xn,
  output logic                       rsp_nc,
  output logic                       inv_done,
  output logic [CNT_W-1:0]           cnt_rd_hit,
  output logic [CNT_W-1:0]           cnt_rd_miss,
  output logic [CNT_W-1:0]           cnt_rd_acc,
  output logic [CNT_W-1:0]           cnt_wr_hit,
  output logic [CNT_W-1:0]           cnt_wr_miss,
  output logic [CNT_W-1:0]           cnt_wr_acc,
  output logic [CNT_W:0]             cnt_hit,
  output logic [CNT_W:0]             cnt_miss,
  output logic [CNT_W:0]             cnt_acc
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TOT_W = CNT_W + 1;

  inv_kind_e          kind;
  logic [ENTRIES-1:0] e_hit;
  logic [ENTRIES-1:0] e_valid;
  logic [PA_W-1:0]    e_pa  [ENTRIES];
  logic [DOM_W-1:0]   e_dom [ENTRIES];
  logic [AP_W-1:0]    e_ap  [ENTRIES];
  logic [ENTRIES-1:0] e_xn;
  logic [ENTRIES-1:0] e_nc;

  assign kind = inv_kind_e'(inv_kind);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_entry #(
      .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W),
      .DOM_W(DOM_W), .AP_W(AP_W), .SHIFT_W(SHIFT_W)
    ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fill_en && (fill_idx == IDX_W'(g))),
      .wr_vpn   (fill_vpn),
      .wr_shift (fill_shift),
      .wr_pfn   (fill_pfn),
      .wr_asid  (fill_asid),
      .wr_dom   (fill_domain),
      .wr_ap    (fill_ap),
      .wr_xn    (fill_xn),
      .wr_nc    (fill_nc),
      .inv_en   (inv_en),
      .inv_kind (kind),
      .inv_va   (inv_va),
      .inv_asid (inv_asid),
      .lk_va    (lk_va),
      .lk_asid  (lk_ctx),
      .lk_hit   (e_hit[g]),
      .lk_pa    (e_pa[g]),
      .dom_q    (e_dom[g]),
      .ap_q     (e_ap[g]),
      .xn_q     (e_xn[g]),
      .nc_q     (e_nc[g]),
      .valid_q  (e_valid[g])
    );
  end

  // Lowest-index hit wins: scan downward so the last assignment is index 0.
  logic              sel_hit;
  logic [PA_W-1:0]   sel_pa;
  logic [DOM_W-1:0]  sel_dom;
  logic [AP_W-1:0]   sel_ap;
  logic              sel_xn;
  logic              sel_nc;

  always_comb begin
    sel_hit = 1'b0;
    sel_pa  = '0;
    sel_dom = '0;
    sel_ap  = '0;
    sel_xn  = 1'b0;
    sel_nc  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (e_hit[i]) begin
        sel_hit = 1'b1;
        sel_pa  = e_pa[i];
        sel_dom = e_dom[i];
        sel_ap  = e_ap[i];
        sel_xn  = e_xn[i];
        sel_nc  = e_nc[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pa     <= '0;
      rsp_domain <= '0;
      rsp_ap     <= '0;
      rsp_xn     <= 1'b0;
      rsp_nc     <= 1'b0;
      inv_done   <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && sel_hit;
      rsp_pa     <= lk_valid ? sel_pa  : '0;
      rsp_domain <= lk_valid ? sel_dom : '0;
      rsp_ap     <= lk_valid ? sel_ap  : '0;
      rsp_xn     <= lk_valid && sel_xn;
      rsp_nc     <= lk_valid && sel_nc;
      inv_done   <= inv_en;
    end
  end

  // Event counters
  logic             is_rd;
  logic             is_wr;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];

  assign is_rd = lk_valid && !lk_write;
  assign is_wr = lk_valid &&  lk_write;

  always_comb begin
    cnt_inc              = '0;
    cnt_inc[CNT_RD_HIT]  = is_rd &&  sel_hit;
    cnt_inc[CNT_RD_MISS] = is_rd && !sel_hit;
    cnt_inc[CNT_RD_ACC]  = is_rd;
    cnt_inc[CNT_WR_HIT]  = is_wr &&  sel_hit;
    cnt_inc[CNT_WR_MISS] = is_wr && !sel_hit;
    cnt_inc[CNT_WR_ACC]  = is_wr;
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    tlb_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[c]),
      .q     (cnt_q[c])
    );
  end

  assign cnt_rd_hit  = cnt_q[CNT_RD_HIT];
  assign cnt_rd_miss = cnt_q[CNT_RD_MISS];
  assign cnt_rd_acc  = cnt_q[CNT_RD_ACC];
  assign cnt_wr_hit  = cnt_q[CNT_WR_HIT];
  assign cnt_wr_miss = cnt_q[CNT_WR_MISS];
  assign cnt_wr_acc  = cnt_q[CNT_WR_ACC];
  assign cnt_hit     = TOT_W'(cnt_rd_hit)  + TOT_W'(cnt_wr_hit);
  assign cnt_miss    = TOT_W'(cnt_rd_miss) + TOT_W'(cnt_wr_miss);
  assign cnt_acc     = TOT_W'(cnt_rd_acc)  + TOT_W'(cnt_wr_acc);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);                                   // R1
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);                                 // R1
  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));               // R2
  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> inv_done);                                      // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_en |=> !inv_done);                                    // R6
  AST_HIT_ONEHOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (e_hit != '0) |-> ((e_hit & ~e_valid) == '0));             // R1
  always_comb begin
    AST_TOTAL_SUMS: assert (cnt_acc == TOT_W'(cnt_rd_acc) + TOT_W'(cnt_wr_acc)
                            && cnt_hit >= TOT_W'(cnt_rd_hit)); // R9
  end

endmodule

// File: tb/tlb_tagged_test.sv
module tlb_tagged_test;
  localparam int CLK_P = 10;
  localparam int NE    = 8;
  localparam int VAW   = 16;
  localparam int PAW   = 20;
  localparam int AW    = 4;
  localparam int DW    = 4;
  localparam int APW   = 3;
  localparam int SW    = 4;
  localparam int CW    = 6;
  localparam longint MAXC = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic           lk_valid = 0, lk_write = 0;
  logic [VAW-1:0] lk_va = '0;
  logic [AW-1:0]  lk_ctx = '0;
  logic           fill_en = 0;
  logic [2:0]     fill_idx = '0;
  logic [VAW-1:0] fill_vpn = '0;
  logic [SW-1:0]  fill_shift = '0;
  logic [PAW-1:0] fill_pfn = '0;
  logic [AW-1:0]  fill_asid = '0;
  logic [DW-1:0]  fill_domain = '0;
  logic [APW-1:0] fill_ap = '0;
  logic           fill_xn = 0, fill_nc = 0;
  logic           inv_en = 0;
  logic [1:0]     inv_kind = '0;
  logic [VAW-1:0] inv_va = '0;
  logic [AW-1:0]  inv_asid = '0;

  logic           rsp_valid, rsp_hit, rsp_xn, rsp_nc, inv_done;
  logic [PAW-1:0] rsp_pa;
  logic [DW-1:0]  rsp_domain;
  logic [APW-1:0] rsp_ap;
  logic [CW-1:0]  c_rh, c_rm, c_ra, c_wh, c_wm, c_wa;
  logic [CW:0]    c_h, c_m, c_a;

  tlb_tagged #(.ENTRIES(NE), .VA_W(VAW), .PA_W(PAW), .ASID_W(AW), .DOM_W(DW),
               .AP_W(APW), .SHIFT_W(SW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_va(lk_va), .lk_ctx(lk_ctx), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_vpn(fill_vpn), .fill_shift(fill_shift), .fill_pfn(fill_pfn),
    .fill_asid(fill_asid), .fill_domain(fill_domain), .fill_ap(fill_ap),
    .fill_xn(fill_xn), .fill_nc(fill_nc), .inv_en(inv_en), .inv_kind(inv_kind),
    .inv_va(inv_va), .inv_asid(inv_asid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_domain(rsp_domain), .rsp_ap(rsp_ap), .rsp_xn(rsp_xn),
    .rsp_nc(rsp_nc), .inv_done(inv_done), .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm),
    .cnt_rd_acc(c_ra), .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm), .cnt_wr_acc(c_wa),
    .cnt_hit(c_h), .cnt_miss(c_m), .cnt_acc(c_a)
  );

  // Reference model
  bit     m_v   [NE];
  longint m_vpn [NE];
  longint m_sh  [NE];
  longint m_pfn [NE];
  longint m_as  [NE];
  longint m_dom [NE];
  longint m_ap  [NE];
  bit     m_xn  [NE];
  bit     m_nc  [NE];
  longint mc    [6];   // rd hit, rd miss, rd acc, wr hit, wr miss, wr acc

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  function automatic bit covers(int i, longint va);
    longint base = m_vpn[i] << m_sh[i];
    return (va >= base) && (va < base + (64'd1 << m_sh[i]));
  endfunction

  function automatic longint phys(int i, longint va);
    longint pa = (m_pfn[i] << m_sh[i]) | (va & ((64'd1 << m_sh[i]) - 1));
    return pa & ((64'd1 << PAW) - 1);
  endfunction

  function automatic longint bump(longint v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock: expectations come from the model state before the edge.
  task automatic step(string tag);
    int  hi = -1;
    bit  e_done = inv_en;
    bit  was_lk = lk_valid;
    bit  was_wr = lk_write;
    longint va = longint'(lk_va);
    if (lk_valid)
      for (int i = NE - 1; i >= 0; i--)
        if (m_v[i] && covers(i, va) && m_as[i] == longint'(lk_ctx)) hi = i;
    @(posedge clk);
    #1;
    if (was_lk) begin
      chk(tag, "rsp_valid", rsp_valid, 1);
      chk(tag, "rsp_hit", rsp_hit, hi >= 0);
      if (hi >= 0) begin
        chk("R2", "rsp_pa", rsp_pa, phys(hi, va));
        chk("R2", "rsp_domain", rsp_domain, m_dom[hi]);
        chk("R2", "rsp_ap", rsp_ap, m_ap[hi]);
        chk("R2", "rsp_xn", rsp_xn, m_xn[hi]);
        chk("R2", "rsp_nc", rsp_nc, m_nc[hi]);
      end else begin
        chk("R2", "rsp_pa_miss", rsp_pa, 0);
      end
      if (!was_wr) begin
        if (hi >= 0) mc[0] = bump(mc[0]); else mc[1] = bump(mc[1]);
        mc[2] = bump(mc[2]);
      end else begin
        if (hi >= 0) mc[3] = bump(mc[3]); else mc[4] = bump(mc[4]);
        mc[5] = bump(mc[5]);
      end
    end else begin
      chk("R1", "rsp_valid_idle", rsp_valid, 0);
    end
    chk("R6", "inv_done", inv_done, e_done);
    chk("R8", "cnt_rd_hit", c_rh, mc[0]);
    chk("R8", "cnt_rd_miss", c_rm, mc[1]);
    chk("R8", "cnt_rd_acc", c_ra, mc[2]);
    chk("R8", "cnt_wr_hit", c_wh, mc[3]);
    chk("R8", "cnt_wr_miss", c_wm, mc[4]);
    chk("R8", "cnt_wr_acc", c_wa, mc[5]);
    chk("R9", "cnt_hit", c_h, mc[0] + mc[3]);
    chk("R9", "cnt_miss", c_m, mc[1] + mc[4]);
    chk("R9", "cnt_acc", c_a, mc[2] + mc[5]);
    // Model update: invalidation, then fill
    if (inv_en)
      for (int i = 0; i < NE; i++) begin
        bit inr = covers(i, longint'(inv_va));
        bit tag_eq = (m_as[i] == longint'(inv_asid));
        case (inv_kind)
          2'd1: if (inr && tag_eq) m_v[i] = 0;
          2'd2: if (tag_eq) m_v[i] = 0;
          2'd3: if (inr) m_v[i] = 0;
          default: ;
        endcase
      end
    if (fill_en) begin
      m_v[fill_idx]   = 1;
      m_vpn[fill_idx] = longint'(fill_vpn);
      m_sh[fill_idx]  = longint'(fill_shift);
      m_pfn[fill_idx] = longint'(fill_pfn);
      m_as[fill_idx]  = longint'(fill_asid);
      m_dom[fill_idx] = longint'(fill_domain);
      m_ap[fill_idx]  = longint'(fill_ap);
      m_xn[fill_idx]  = fill_xn;
      m_nc[fill_idx]  = fill_nc;
    end
    lk_valid = 0;
    fill_en  = 0;
    inv_en   = 0;
  endtask

  task automatic set_fill(int idx, int vpn, int sh, int pfn, int asid);
    fill_en = 1; fill_idx = 3'(idx); fill_vpn = VAW'(vpn); fill_shift = SW'(sh);
    fill_pfn = PAW'(pfn); fill_asid = AW'(asid);
    fill_domain = DW'($urandom); fill_ap = APW'($urandom);
    fill_xn = 1'($urandom); fill_nc = 1'($urandom);
  endtask

  task automatic set_lk(int va, int asid, bit wr);
    lk_valid = 1; lk_va = VAW'(va); lk_ctx = AW'(asid); lk_write = wr;
  endtask

  task automatic set_inv(int kind, int va, int asid);
    inv_en = 1; inv_kind = 2'(kind); inv_va = VAW'(va); inv_asid = AW'(asid);
  endtask

  task automatic fill(int idx, int vpn, int sh, int pfn, int asid);
    set_fill(idx, vpn, sh, pfn, asid); step("R7");
  endtask

  task automatic look(int va, int asid, string tag);
    set_lk(va, asid, 0); step(tag);
  endtask

  task automatic expect_hit(int va, int asid, bit exp, string tag);
    set_lk(va, asid, 0); step(tag);
    chk(tag, "directed_hit", rsp_hit, exp);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    for (int c = 0; c < 6; c++) mc[c] = 0;
    chk("R11", "rsp_valid", rsp_valid, 0);
    chk("R11", "inv_done", inv_done, 0);
    chk("R11", "cnt_acc", c_a, 0);
    chk("R11", "cnt_rd_hit", c_rh, 0);
    chk("R11", "cnt_wr_acc", c_wa, 0);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_vpn[i] = 0; m_sh[i] = 0; m_pfn[i] = 0; m_as[i] = 0;
      m_dom[i] = 0; m_ap[i] = 0; m_xn[i] = 0; m_nc[i] = 0;
    end
    for (int c = 0; c < 6; c++) mc[c] = 0;
    @(negedge clk);
    do_reset();
    expect_hit(16'h3456, 3, 0, "R11");

    // R1 / R2: range boundaries, tag match, translation
    fill(0, 16'h3, 12, 20'h0AB, 3);
    expect_hit(16'h3456, 3, 1, "R1");
    expect_hit(16'h3FFF, 3, 1, "R1");
    expect_hit(16'h4000, 3, 0, "R1");
    expect_hit(16'h2FFF, 3, 0, "R1");
    expect_hit(16'h3456, 4, 0, "R1");
    fill(1, 16'h34, 8, 20'h00001, 3);
    fill(2, 16'h34, 8, 20'h00777, 7);
    expect_hit(16'h3456, 3, 1, "R2");           // slot 0 outranks slot 1
    chk("R2", "priority_pa", rsp_pa, 20'hAB456);

    // R3: address+tag clears all overlapping hits, keeps other tag
    set_inv(1, 16'h3456, 3); step("R3");
    expect_hit(16'h3456, 3, 0, "R3");
    expect_hit(16'h3010, 3, 0, "R3");
    expect_hit(16'h3456, 7, 1, "R3");

    // R4: tag only
    fill(3, 16'h50, 8, 20'h00050, 5);
    fill(4, 16'h60, 8, 20'h00060, 5);
    fill(5, 16'h70, 8, 20'h00070, 6);
    set_inv(2, 16'h0000, 5); step("R4");
    expect_hit(16'h5010, 5, 0, "R4");
    expect_hit(16'h6010, 5, 0, "R4");
    expect_hit(16'h7010, 6, 1, "R4");

    // R5: address only, per-slot size, tag ignored
    fill(0, 16'h8, 12, 20'h00008, 1);
    fill(1, 16'h80, 8, 20'h00080, 2);
    fill(6, 16'h81, 8, 20'h00081, 1);
    set_inv(3, 16'h80F0, 9); step("R5");
    expect_hit(16'h8010, 1, 0, "R5");
    expect_hit(16'h8010, 2, 0, "R5");
    expect_hit(16'h8110, 1, 1, "R5");

    // R6: kind 0 completes and clears nothing; lookup right after a command
    set_inv(0, 16'h8110, 1); step("R6");
    expect_hit(16'h8110, 1, 1, "R6");
    set_inv(2, 16'h0, 6); step("R6");
    expect_hit(16'h7010, 6, 0, "R6");

    // R7: fill and matching invalidation in the same cycle
    fill(3, 16'hA0, 8, 20'h000A0, 4);
    set_fill(7, 16'h90, 8, 20'h00090, 4);
    set_inv(2, 16'h0, 4);
    step("R7");
    expect_hit(16'h9010, 4, 1, "R7");
    expect_hit(16'hA010, 4, 0, "R7");

    // R10: saturation of write counters
    for (int k = 0; k < 70; k++) begin
      set_lk(16'hF000, 15, 1); step("R10");
    end
    chk("R10", "cnt_wr_acc_sat", c_wa, MAXC);
    chk("R10", "cnt_wr_miss_sat", c_wm, MAXC);

    // Random mix of fills, invalidations and lookups
    for (int n = 0; n < 3000; n++) begin
      int pick = int'($urandom % NE);
      int va;
      int asid;
      if (m_v[pick] && ($urandom % 2 == 0)) begin
        va = int'((m_vpn[pick] << m_sh[pick]) + longint'($urandom % (1 << m_sh[pick])));
        asid = int'(m_as[pick]);
      end else begin
        va = int'($urandom % 65536);
        asid = int'($urandom % 16);
      end
      if ($urandom % 5 == 0) begin
        int sh = 4 + int'($urandom % 9);
        set_fill(int'($urandom % NE), int'(($urandom % 65536) >> sh), sh,
                 int'($urandom % (1 << PAW)), int'($urandom % 4));
      end
      if ($urandom % 10 == 0) set_inv(int'($urandom % 4), va, asid);
      if ($urandom % 4 != 0) set_lk(va, asid, 1'($urandom));
      step("R1");
    end

    // R11: reset in mid run clears slots and counters
    fill(2, 16'h12, 8, 20'h00012, 2);
    @(negedge clk);
    do_reset();
    expect_hit(16'h1234, 2, 0, "R11");

    finish_run();
  end

endmodule